// File: doc/BRIEF.md
# Configurable Output Macrocell

This block is one output stage of a small programmable logic device. It receives a sum-of-products result and an output-enable result from the logic array, together with two terms shared by every macrocell: one clears the storage flip-flop asynchronously, and one presets it on the next rising clock edge. A two-bit configuration selects whether the pin shows the flip-flop or the raw sum term, and whether the pin is active high or active low. The block drives a tri-state pin, given as data plus enable, and returns one feedback bit to the array.

The clear and preset terms act on the flip-flop ahead of the polarity stage. The level a cleared register shows at the pin therefore depends on the polarity chosen. In registered mode the feedback is the inverted flip-flop output, so a registered pin cannot serve as an input. In combinational mode the feedback is taken from the pin side of the tri-state buffer. When the buffer is off, that is the externally driven level. A preload port forces the flip-flop to any value on a clock edge, so that test sequences can start from states the logic would never reach.

Top module: `out_macrocell`

## Requirements
- R1: With cfgMode = 2'b00 (registered, active high), padOut equals the flip-flop Q. On each rising edge, with no clear, preload or preset active, Q takes sumTerm.
- R2: With cfgMode = 2'b01 (registered, active low), padOut equals the inverse of Q.
- R3: With cfgMode = 2'b10 (combinational, active low), padOut equals the inverse of sumTerm in the same cycle, with no clock needed.
- R4: With cfgMode = 2'b11 (combinational, active high), padOut equals sumTerm in the same cycle.
- R5: A high arTerm clears Q to 0 at once, without a clock edge. padOut then reads 0 in mode 2'b00 and 1 in mode 2'b01.
- R6: A high spTerm sets Q to 1 on the next rising edge. When arTerm and spTerm are both high, Q stays 0.
- R7: A high preloadEn loads preloadVal into Q on the rising edge. This overrides both sumTerm and spTerm, but not arTerm.
- R8: A low rstN clears Q to 0 asynchronously, both at power-up and during operation.
- R9: padOe follows oeTerm in every mode. A constant 1 gives a dedicated output, a constant 0 a dedicated input, and anything else dynamic I/O.
- R10: In registered modes (cfgMode[1] = 0), fbOut equals the inverse of Q whatever padIn and oeTerm are.
- R11: In combinational modes (cfgMode[1] = 1), fbOut equals padOut while padOe is 1, and equals padIn while padOe is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock, rising edge |
| rstN | input | 1 | Power-up reset, active low, asynchronous |
| sumTerm | input | 1 | Sum-of-products result from the array |
| oeTerm | input | 1 | Output-enable product term |
| arTerm | input | 1 | Shared asynchronous clear term, active high |
| spTerm | input | 1 | Shared synchronous preset term, active high |
| cfgMode | input | 2 | Mode select: bit 1 picks combinational, bit 0 picks the polarity variant |
| preloadEn | input | 1 | Test preload strobe |
| preloadVal | input | 1 | Value forced into the flip-flop on preload |
| padIn | input | 1 | Level seen at the pin when the macrocell does not drive it |
| padOut | output | 1 | Data to the pin buffer, after polarity |
| padOe | output | 1 | Enable for the pin buffer |
| fbOut | output | 1 | Feedback bit returned to the array |

## Verification
The bench runs all four cfgMode codes with sumTerm toggling, so the two registered variants can be told apart from the two combinational ones and true polarity from inverted polarity. It holds padIn opposite to padOut while toggling oeTerm. This separates feedback taken from the flip-flop from feedback taken from the pin, and pin-side feedback with the buffer on from the same feedback with the buffer off. Clear, preset and preload are applied alone and then overlapped, with sumTerm set against the forced value. A wrong priority order therefore shows up as a wrong Q at the pin. A clear applied between clock edges is checked before any edge arrives, which confirms that it acts at once.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int CFG_W = 2;

  typedef enum logic [CFG_W-1:0] {
    MODE_REG_HI  = 2'b00,
    MODE_REG_LO  = 2'b01,
    MODE_COMB_LO = 2'b10,
    MODE_COMB_HI = 2'b11
  } cellMode_e;

  typedef enum logic [1:0] {
    NXT_SUM     = 2'd0,
    NXT_PRESET  = 2'd1,
    NXT_PRELOAD = 2'd2
  } nextSel_e;

  typedef struct packed {
    logic     regMode;
    logic     invertOut;
    nextSel_e nextSel;
  } cellStrobe_t;
endpackage

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_pkg::*;
(
  input  logic [CFG_W-1:0] cfgMode,
  input  logic             spTerm,
  input  logic             preloadEn,
  output cellStrobe_t      strobe
);
  cellMode_e modeSel;

  assign modeSel = cellMode_e'(cfgMode);

  always_comb begin
    strobe.regMode   = 1'b1;
    strobe.invertOut = 1'b0;
    case (modeSel)
      MODE_REG_HI:  begin strobe.regMode = 1'b1; strobe.invertOut = 1'b0; end
      MODE_REG_LO:  begin strobe.regMode = 1'b1; strobe.invertOut = 1'b1; end
      MODE_COMB_LO: begin strobe.regMode = 1'b0; strobe.invertOut = 1'b1; end
      MODE_COMB_HI: begin strobe.regMode = 1'b0; strobe.invertOut = 1'b0; end
      default:      begin strobe.regMode = 1'b1; strobe.invertOut = 1'b0; end
    endcase
  end

  // Edge priority below the asynchronous clear: preload, then preset, then D.
  always_comb begin
    if (preloadEn)   strobe.nextSel = NXT_PRELOAD;
    else if (spTerm) strobe.nextSel = NXT_PRESET;
    else             strobe.nextSel = NXT_SUM;
  end
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        arTerm,
  input  logic        sumTerm,
  input  logic        oeTerm,
  input  logic        preloadVal,
  input  logic        padIn,
  input  cellStrobe_t strobe,
  output logic        padOut,
  output logic        padOe,
  output logic        fbOut
);
  logic regQ;
  logic nextQ;
  logic preVal;
  logic pinSide;

  always_comb begin
    case (strobe.nextSel)
      NXT_PRELOAD: nextQ = preloadVal;
      NXT_PRESET:  nextQ = 1'b1;
      default:     nextQ = sumTerm;
    endcase
  end

  always_ff @(posedge clk or negedge rstN or posedge arTerm) begin
    if (!rstN)       regQ <= 1'b0;
    else if (arTerm) regQ <= 1'b0;
    else             regQ <= nextQ;
  end

  assign preVal  = strobe.regMode ? regQ : sumTerm;
  assign padOut  = preVal ^ strobe.invertOut;
  assign padOe   = oeTerm;
  assign pinSide = oeTerm ? padOut : padIn;
  assign fbOut   = strobe.regMode ? ~regQ : pinSide;
endmodule

// File: rtl/out_macrocell.sv
module out_macrocell
  import mc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             sumTerm,
  input  logic             oeTerm,
  input  logic             arTerm,
  input  logic             spTerm,
  input  logic [CFG_W-1:0] cfgMode,
  input  logic             preloadEn,
  input  logic             preloadVal,
  input  logic             padIn,
  output logic             padOut,
  output logic             padOe,
  output logic             fbOut
);
  cellStrobe_t strobe;

  mc_ctrl uCtrl (
    .cfgMode   (cfgMode),
    .spTerm    (spTerm),
    .preloadEn (preloadEn),
    .strobe    (strobe)
  );

  mc_datapath uDp (
    .clk        (clk),
    .rstN       (rstN),
    .arTerm     (arTerm),
    .sumTerm    (sumTerm),
    .oeTerm     (oeTerm),
    .preloadVal (preloadVal),
    .padIn      (padIn),
    .strobe     (strobe),
    .padOut     (padOut),
    .padOe      (padOe),
    .fbOut      (fbOut)
  );
endmodule

// File: rtl/mc_checker.sv
module mc_checker (
  input logic       clk,
  input logic       rstN,
  input logic       sumTerm,
  input logic       oeTerm,
  input logic       arTerm,
  input logic       spTerm,
  input logic [1:0] cfgMode,
  input logic       preloadEn,
  input logic       preloadVal,
  input logic       padIn,
  input logic       padOut,
  input logic       padOe,
  input logic       fbOut
);
  a_r3_comb_low: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode == 2'b10) |-> (padOut == !sumTerm));

  a_r4_comb_high: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode == 2'b11) |-> (padOut == sumTerm));

  a_r5_clear_now: assert property (@(posedge clk) disable iff (!rstN)
    (arTerm && cfgMode == 2'b00) |-> (padOut == 1'b0));

  a_r6_preset_edge: assert property (@(posedge clk) disable iff (!rstN)
    (spTerm && !arTerm && !preloadEn && cfgMode == 2'b00)
      |=> (arTerm || cfgMode != 2'b00 || padOut == 1'b1));

  a_r7_preload_edge: assert property (@(posedge clk) disable iff (!rstN)
    (preloadEn && !arTerm && cfgMode == 2'b00)
      |=> (arTerm || cfgMode != 2'b00 || padOut == $past(preloadVal)));

  a_r10_reg_feedback: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode[1] == 1'b0) |-> (fbOut == !(padOut ^ cfgMode[0])));

  a_r11_pin_feedback: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode[1] && !padOe) |-> (fbOut == padIn));
endmodule

bind out_macrocell mc_checker uChk (.*);

// File: tb/out_macrocell_test.sv
`timescale 1ns/1ps
module out_macrocell_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sumTerm = 1'b0;
  logic       oeTerm = 1'b1;
  logic       arTerm = 1'b0;
  logic       spTerm = 1'b0;
  logic [1:0] cfgMode = 2'b00;
  logic       preloadEn = 1'b0;
  logic       preloadVal = 1'b0;
  logic       padIn = 1'b0;
  logic       padOut;
  logic       padOe;
  logic       fbOut;

  typedef struct {
    logic  expOut;
    logic  expOe;
    logic  expFb;
    string tag;
  } sbItem_t;

  sbItem_t sbQueue[$];
  int      total = 0;
  int      bad = 0;
  logic    modelQ = 1'b0;
  bit      finished = 1'b0;

  always #4 clk = ~clk;

  out_macrocell uut (
    .clk(clk), .rstN(rstN), .sumTerm(sumTerm), .oeTerm(oeTerm),
    .arTerm(arTerm), .spTerm(spTerm), .cfgMode(cfgMode),
    .preloadEn(preloadEn), .preloadVal(preloadVal), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .fbOut(fbOut)
  );

  function automatic sbItem_t predict(string tag);
    sbItem_t it;
    case (cfgMode)
      2'b00:   it.expOut = modelQ;
      2'b01:   it.expOut = !modelQ;
      2'b10:   it.expOut = !sumTerm;
      default: it.expOut = sumTerm;
    endcase
    it.expOe = oeTerm;
    if (!cfgMode[1]) it.expFb = !modelQ;
    else             it.expFb = oeTerm ? it.expOut : padIn;
    it.tag = tag;
    return it;
  endfunction

  task automatic expectNow(string tag);
    #1;
    if (!rstN || arTerm) modelQ = 1'b0;
    sbQueue.push_back(predict(tag));
  endtask

  task automatic tick(string tag);
    @(posedge clk);
    if (!rstN || arTerm) modelQ = 1'b0;
    else if (preloadEn)  modelQ = preloadVal;
    else if (spTerm)     modelQ = 1'b1;
    else                 modelQ = sumTerm;
    #1;
    sbQueue.push_back(predict(tag));
  endtask

  task automatic atNeg();
    @(negedge clk);
  endtask

  initial begin
    sbItem_t it;
    forever begin
      wait (sbQueue.size() > 0);
      it = sbQueue.pop_front();
      total++;
      if (padOut !== it.expOut || padOe !== it.expOe || fbOut !== it.expFb) begin
        bad++;
        $display("FAIL %s: out/oe/fb actual=%b%b%b expected=%b%b%b",
                 it.tag, padOut, padOe, fbOut, it.expOut, it.expOe, it.expFb);
      end
    end
  end

  initial begin
    #1600000;
    if (!finished) begin
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R8 power-up state
    expectNow("R8 reset state");
    atNeg(); rstN = 1'b1;

    // R1 registered active high
    atNeg(); sumTerm = 1'b1; tick("R1 load one");
    atNeg(); sumTerm = 1'b0; tick("R1 load zero");
    atNeg(); sumTerm = 1'b1; tick("R1 load one again");

    // R2 registered active low
    atNeg(); cfgMode = 2'b01; expectNow("R2 inverted Q");
    atNeg(); sumTerm = 1'b0; tick("R2 inverted zero");

    // R3 combinational active low, R11 with buffer on
    atNeg(); cfgMode = 2'b10; sumTerm = 1'b1; padIn = 1'b1; expectNow("R3 sum one");
    atNeg(); sumTerm = 1'b0; padIn = 1'b0; expectNow("R3 R11 sum zero, pin fed back");

    // R4 combinational active high, R11 with buffer off, R9
    atNeg(); cfgMode = 2'b11; sumTerm = 1'b1; padIn = 1'b0; expectNow("R4 sum one");
    atNeg(); oeTerm = 1'b0; padIn = 1'b0; expectNow("R11 R9 off, pad low");
    atNeg(); padIn = 1'b1; sumTerm = 1'b0; expectNow("R11 off, pad high");

    // R10 registered feedback ignores pin
    atNeg(); cfgMode = 2'b00; sumTerm = 1'b1; padIn = 1'b1; tick("R10 Q one");
    atNeg(); padIn = 1'b0; oeTerm = 1'b1; expectNow("R10 pad changed");

    // R5 immediate clear with polarity
    atNeg(); sumTerm = 1'b1; arTerm = 1'b1; expectNow("R5 clear active high");
    atNeg(); cfgMode = 2'b01; expectNow("R5 clear active low");
    tick("R5 held through edge");
    atNeg(); arTerm = 1'b0; cfgMode = 2'b00; expectNow("R5 released");

    // R6 preset and clear priority
    atNeg(); sumTerm = 1'b0; spTerm = 1'b1; tick("R6 preset");
    atNeg(); arTerm = 1'b1; expectNow("R6 clear beats preset now");
    tick("R6 clear beats preset at edge");
    atNeg(); arTerm = 1'b0; spTerm = 1'b0; expectNow("R6 released");

    // R7 preload priority
    atNeg(); sumTerm = 1'b1; preloadEn = 1'b1; preloadVal = 1'b1; tick("R7 preload one");
    atNeg(); preloadVal = 1'b0; tick("R7 preload zero over sum");
    atNeg(); sumTerm = 1'b0; preloadVal = 1'b1; tick("R7 preload one over sum");
    atNeg(); spTerm = 1'b1; preloadVal = 1'b0; tick("R7 preload over preset");
    atNeg(); preloadEn = 1'b0; spTerm = 1'b0; sumTerm = 1'b1; tick("R1 after preload");

    // R8 reset during operation
    atNeg(); rstN = 1'b0; expectNow("R8 reset mid run");
    atNeg(); rstN = 1'b1; sumTerm = 1'b0; tick("R8 after release");

    wait (sbQueue.size() == 0);
    #2;
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule